// File: doc/BRIEF.md
# Priority-Level Interrupt Acceptance Controller

This block collects maskable interrupt requests from a parameterised number of sources, eight by default. Each source owns a latched pending flag and a 3-bit level field. A global enable bit and a 3-bit processor threshold decide which pending requests are eligible. Each cycle the block presents the single best eligible request: its source index and its level. A one-cycle take pulse from the processor side accepts it. The block then raises an acknowledge and clears that source's pending flag on the same clock edge.

Software reaches the storage through a small register port. Address 0 holds the enable in bit 0. Address 1 holds the threshold in bits 2:0. Address 2 holds the pending flags, with bit i belonging to source i. Addresses N_SRC through 2*N_SRC-1 hold the level fields, with source i at address N_SRC+i. Read data is combinational from the selected address. Unmapped addresses read as zero.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, every pending flag, level field, the enable bit and the threshold read as zero, and `irq_valid` is 0.
- R2: A 1 on `hw_evt[i]` sets pending flag i at the next clock edge.
- R3: Writing address 2 clears each pending flag whose data bit is 0. A data bit of 1 leaves its flag unchanged, so software can never set a flag.
- R4: A level field of 0 keeps its source from ever being presented. Values 1 to 7 are levels, and 7 is the highest.
- R5: A source is eligible only when the enable bit is 1, its pending flag is 1, and its level is strictly greater than the threshold. `irq_valid` is 1 exactly when some source is eligible.
- R6: A threshold of 7 blocks every source. A threshold of 0 admits every level from 1 to 7.
- R7: `irq_idx` and `irq_lvl` name the eligible source with the highest level. When several sources share that level, the lowest index wins.
- R8: When `take` is 1 while `irq_valid` is 1, `irq_ack` is 1 in that cycle, and the winner's pending flag is 0 after the edge.
- R9: When a hardware event for a flag arrives in the same cycle as a software clear or a take of that flag, the flag ends up set.
- R10: The enable bit, the threshold, the pending flags and the level fields are separate storage. A write to one address never changes what another address reads back.
- R11: A `take` while `irq_valid` is 0 gives no acknowledge and changes no pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | N_SRC | Per-source hardware request events |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data for `reg_addr` |
| take | input | 1 | Single-cycle accept pulse from the processor side |
| irq_valid | output | 1 | An eligible request is presented |
| irq_idx | output | IDX_W | Index of the presented source |
| irq_lvl | output | 3 | Level of the presented source |
| irq_ack | output | 1 | Acceptance acknowledge |

## Verification
Several properties are checked on every cycle. The enable bit and the maximum threshold suppress `irq_valid`. A presented request is pending and sits above the threshold. Hardware events always land in their flags. Taking a request clears its flag unless a new event arrives for it. No flag ever rises without a hardware event. Which source wins among several eligible ones, including ties, is left to the bench. It sweeps every threshold and both enable values over several level patterns. It drains requests in order and compares readback after each register write.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int AW = $clog2(2 * N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] hw_evt,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  input  logic             take,
  output logic             irq_valid,
  output logic [IDX_W-1:0] irq_idx,
  output logic [LVL_W-1:0] irq_lvl,
  output logic             irq_ack
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [N_SRC-1:0] pend;
  logic [LVL_W-1:0] lvl [N_SRC];
  logic             ien;
  logic [LVL_W-1:0] thr;
  logic [N_SRC-1:0] elig, sw_clr, take_clr;

  wire wr_en   = reg_we && reg_addr == AW'(0);
  wire wr_thr  = reg_we && reg_addr == AW'(1);
  wire wr_pend = reg_we && reg_addr == AW'(2);

  assign sw_clr = wr_pend ? ~reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien <= 1'b0;
      thr <= '0;
    end else begin
      if (wr_en)  ien <= reg_wdata[0];
      if (wr_thr) thr <= reg_wdata[LVL_W-1:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      wire wr_lvl = reg_we && reg_addr == AW'(N_SRC + g);
      always_ff @(posedge clk) begin
        if (!rst_n)      lvl[g] <= '0;
        else if (wr_lvl) lvl[g] <= reg_wdata[LVL_W-1:0];
      end
      assign elig[g] = ien && pend[g] && (lvl[g] > thr);
    end
  endgenerate

  always_comb begin
    irq_valid = 1'b0;
    irq_idx   = '0;
    irq_lvl   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i] && lvl[i] >= irq_lvl) begin
        irq_valid = 1'b1;
        irq_idx   = IDX_W'(i);
        irq_lvl   = lvl[i];
      end
    end
  end

  assign irq_ack  = take && irq_valid;
  assign take_clr = irq_ack ? (N_SRC'(1) << irq_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~sw_clr & ~take_clr) | hw_evt;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0))      reg_rdata[0] = ien;
    else if (reg_addr == AW'(1)) reg_rdata[LVL_W-1:0] = thr;
    else if (reg_addr == AW'(2)) reg_rdata = pend;
    else if (reg_addr >= AW'(N_SRC))
      reg_rdata[LVL_W-1:0] = lvl[IDX_W'(reg_addr - AW'(N_SRC))];
  end

  AST_EN_GATE:   assert property (@(posedge clk) disable iff (!rst_n) !ien |-> !irq_valid); // R5
  AST_THR_MAX:   assert property (@(posedge clk) disable iff (!rst_n) thr == LVL_MAX |-> !irq_valid); // R6
  AST_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n) irq_valid |-> (irq_lvl > thr && pend[irq_idx])); // R5
  AST_TAKE_CLR:  assert property (@(posedge clk) disable iff (!rst_n)
                   (irq_ack && !hw_evt[irq_idx]) |=> !pend[$past(irq_idx)]); // R8
  AST_HW_SET:    assert property (@(posedge clk) disable iff (!rst_n)
                   (hw_evt != '0) |=> ((pend & $past(hw_evt)) == $past(hw_evt))); // R9
  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
                   (hw_evt == '0) |=> ((pend & ~$past(pend)) == '0)); // R3
  AST_LVL0_OFF:  assert property (@(posedge clk) disable iff (!rst_n) irq_valid |-> irq_lvl != '0); // R4
endmodule

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;
  localparam int N = 8;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0, reg_we = 0, take = 0;
  logic [N-1:0] hw_evt = '0, reg_wdata = '0, reg_rdata;
  logic [AW-1:0] reg_addr = '0;
  logic irq_valid, irq_ack;
  logic [2:0] irq_idx, irq_lvl;

  irq_level_arbiter #(.N_SRC(N), .LVL_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .take(take), .irq_valid(irq_valid),
    .irq_idx(irq_idx), .irq_lvl(irq_lvl), .irq_ack(irq_ack));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [N-1:0] m_pend = '0;
  int m_lvl [N];
  int m_ien = 0, m_thr = 0;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(int a, int d);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = N'(d);
    tick();
    reg_we = 0;
    if (a == 0) m_ien = d & 1;
    else if (a == 1) m_thr = d & 7;
    else if (a == 2) m_pend = m_pend & N'(d);
    else if (a >= N) m_lvl[a - N] = d & 7;
  endtask

  task automatic rd(int a, output int d);
    reg_addr = AW'(a); #1; d = int'(reg_rdata);
  endtask

  task automatic hw(int m);
    hw_evt = N'(m); tick(); hw_evt = '0;
    m_pend = m_pend | N'(m);
  endtask

  task automatic expect_win(output bit v, output int idx, output int l);
    v = 0; idx = 0; l = 0;
    for (int i = 0; i < N; i++)
      if (m_ien == 1 && m_pend[i] && m_lvl[i] > m_thr && m_lvl[i] > l) begin
        v = 1; idx = i; l = m_lvl[i];
      end
  endtask

  task automatic check_out(string req);
    bit v; int idx, l;
    expect_win(v, idx, l);
    chk(req, int'(irq_valid), int'(v));
    if (v) begin
      chk(req, int'(irq_idx), idx);
      chk(req, int'(irq_lvl), l);
    end
  endtask

  task automatic do_take(string req);
    bit v; int idx, l, d;
    expect_win(v, idx, l);
    take = 1; #1;
    chk(req, int'(irq_ack), int'(v));
    tick(); take = 0;
    if (v) m_pend[idx] = 1'b0;
    rd(2, d); chk(req, d, int'(m_pend));
  endtask

  initial begin
    int d;
    bit v; int idx, l;
    for (int i = 0; i < N; i++) m_lvl[i] = 0;
    repeat (3) tick();
    rst_n = 1; tick();

    // R1 reset state
    for (int a = 0; a < 2 * N; a++) begin rd(a, d); chk("R1", d, 0); end
    chk("R1", int'(irq_valid), 0);

    // R5 R6 R7 sweeps over level patterns, thresholds and enable
    for (int p = 0; p < 4; p++) begin
      int mask;
      mask = (p == 1) ? 'hA5 : (p == 2) ? 'h5A : 'hFF;
      wr(2, 0);
      for (int i = 0; i < N; i++) wr(N + i, (i * (2 * p + 3) + p) % 8);
      hw(mask);
      rd(2, d); chk("R2", d, mask);
      for (int e = 0; e < 2; e++)
        for (int t = 0; t < 8; t++) begin
          wr(0, e); wr(1, t);
          check_out(t == 7 ? "R6" : (e == 0 ? "R5" : "R7"));
        end
    end

    // R8 drain in priority order
    wr(0, 1); wr(1, 0);
    for (int k = 0; k < N + 1; k++) begin
      check_out("R8");
      do_take("R8");
    end

    // R7 ties: lowest index first
    for (int i = 0; i < N; i++) wr(N + i, 5);
    hw('hFF);
    for (int k = 0; k < N; k++) begin
      chk("R7", int'(irq_idx), k);
      do_take("R7");
    end

    // R4 level 0 never presented
    wr(N + 4, 0); hw('h10);
    chk("R4", int'(irq_valid), 0);

    // R11 take with nothing valid
    do_take("R11");
    rd(2, d); chk("R11", d, 'h10);

    // R3 writing ones has no effect, zeros clear
    wr(2, 'hFF); rd(2, d); chk("R3", d, 'h10);
    wr(2, 'hEF); rd(2, d); chk("R3", d, 0);

    // R9 hw event beats software clear
    reg_we = 1; reg_addr = 2; reg_wdata = '0; hw_evt = 8'h04;
    tick(); reg_we = 0; hw_evt = '0;
    rd(2, d); chk("R9", d, 'h04);
    // R9 hw event beats take on the winner
    wr(N + 2, 6); m_pend = 'h04;
    chk("R9", int'(irq_idx), 2);
    take = 1; hw_evt = 8'h04; #1;
    chk("R9", int'(irq_ack), 1);
    tick(); take = 0; hw_evt = '0;
    rd(2, d); chk("R9", d, 'h04);

    // R10 independence of storage
    wr(1, 3); wr(0, 0);
    rd(1, d); chk("R10", d, 3);
    rd(N + 2, d); chk("R10", d, 6);
    wr(N + 1, 7);
    rd(0, d); chk("R10", d, 0);
    rd(1, d); chk("R10", d, 3);
    rd(2, d); chk("R10", d, 'h04);
    rd(N + 2, d); chk("R10", d, 6);
    wr(1, 0);
    rd(N + 1, d); chk("R10", d, 7);
    rd(0, d); chk("R10", d, 0);
    expect_win(v, idx, l);
    chk("R10", int'(irq_valid), int'(v));

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule